// File: doc/BRIEF.md
# Trapezoidal Pulse Test Stimulus Generator

This block produces a digital sample stream, one sample per clock, that forms a periodic trapezoid for driving a converter's input path during a quick pass/fail pre-screen. Each period runs through four phases in a fixed order. The value first ramps linearly from zero up to the programmed amplitude. It then holds at the amplitude, ramps linearly back down, and finally rests at zero until the period ends. The two ramps are deliberately slow so that the converter under test can settle. The length of each phase is set on its own, in sample clocks.

The period is given in fixed point, as whole samples plus a binary fraction. A phase accumulator spreads the fractional part over the run, so a repetition rate that is not a whole number of samples does not drift. When a run is started, the block latches all settings. It then spends a short setup phase computing the ramp slopes with a shift-and-subtract divider. After that it emits the programmed number of periods, marking the first sample of each one, and stops at zero with a done flag. A count of zero means the run continues until it is stopped.

Top module: `trap_pulse_gen`

## Requirements
- R1: After reset the outputs read sample_out 0, running 0, period_strobe 0, done 0 and periods_done 0.
- R2: With P = cfg_period / 2^FW, period k (counting from 0) lasts floor((k+1)·P) − floor(k·P) samples. period_strobe is 1 on the first sample of every period and 0 on all other samples. running is 1 on every emitted sample.
- R3: For sample index n inside a period with 0 ≤ n < R (R = latched rise length), the output is floor(n·Ir / 2^RF), where Ir = floor(A·2^RF / R) and A is the latched amplitude.
- R4: For indices R ≤ n < R+H (H = latched high length), the output equals A exactly.
- R5: For indices n = R+H+m with 0 ≤ m < F (F = latched fall length), the output is floor((A·2^RF − m·If) / 2^RF), where If = floor(A·2^RF / F).
- R6: From index R+H+F until the end of the period, the output is 0.
- R7: A phase whose length is 0 is skipped. For example, with R = 0 and H > 0 the first sample of each period is A.
- R8: With a nonzero cfg_count, once cfg_count periods are complete the block shows done 1, running 0 and sample_out 0, with periods_done equal to cfg_count, and it stays there. A cfg_count of 0 runs until stopped.
- R9: periods_done reads k throughout period k (modulo 2^NW) and changes only on the first sample of a period.
- R10: A stop pulse during setup or a run returns the block to idle on the next clock: running 0, done 0, sample_out 0.
- R11: Changing the settings inputs during a run, or pulsing start during a run, has no effect on the waveform, the strobe or the count.
- R12: No emitted sample exceeds the latched amplitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run and latches the settings; accepted only when idle or done |
| stop | input | 1 | Aborts setup or a run; has priority over start |
| cfg_amp | input | DW | Plateau amplitude |
| cfg_rise | input | CW | Rising ramp length in samples |
| cfg_high | input | CW | High plateau length in samples |
| cfg_fall | input | CW | Falling ramp length in samples |
| cfg_period | input | CW+FW | Period in samples, with FW fraction bits |
| cfg_count | input | NW | Number of periods, 0 for continuous |
| sample_out | output | DW | Stimulus sample |
| running | output | 1 | Samples are being emitted |
| period_strobe | output | 1 | First sample of a period |
| periods_done | output | NW | Periods completed in this run |
| done | output | 1 | Programmed number of periods has been emitted |

## Verification
The bench builds the block with 8-bit samples and durations, 4 fraction bits in the period, and 8 fraction bits in the slopes. This keeps the slope divider at 16 steps and every period near 20 to 30 samples, so each run can be compared against arithmetic models sample by sample. The sweep covers every combination of zero and nonzero rise, high and fall lengths, each with its own fractional period. Further runs use an integer period, a 20-period run that exposes any accumulator drift, continuous mode ended by stop, and a run whose settings and start input are disturbed while it is active.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SETUP,
      ST_RUN,
      ST_DONE
   } tpg_state_t;

   typedef enum logic [1:0] {
      SG_RISE,
      SG_HIGH,
      SG_FALL,
      SG_LOW
   } tpg_seg_t;

   // successor in the fixed phase order
   function automatic tpg_seg_t tpg_succ(input tpg_seg_t s);
      case (s)
         SG_RISE: return SG_HIGH;
         SG_HIGH: return SG_FALL;
         default: return SG_LOW;
      endcase
   endfunction

   // first phase at or after 'from' whose length is nonzero
   function automatic tpg_seg_t tpg_first_seg(input tpg_seg_t from,
                                              input logic r_nz,
                                              input logic h_nz,
                                              input logic f_nz);
      if (from == SG_RISE && r_nz) return SG_RISE;
      if ((from == SG_RISE || from == SG_HIGH) && h_nz) return SG_HIGH;
      if (from != SG_LOW && f_nz) return SG_FALL;
      return SG_LOW;
   endfunction

endpackage

// File: rtl/tpg_div.sv
module tpg_div #(
   parameter int NUMW = 24,
   parameter int DENW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            go,
   input  logic [NUMW-1:0] num,
   input  logic [DENW-1:0] den,
   output logic [NUMW-1:0] quo,
   output logic            busy
);
   localparam int CNTW = $clog2(NUMW + 1);

   logic [NUMW-1:0] sh_q, q_q;
   logic [DENW-1:0] rem_q, den_q;
   logic [CNTW-1:0] cnt_q;
   logic [DENW:0]   trial;
   logic            fits;

   assign trial = {rem_q, sh_q[NUMW-1]};
   assign fits  = (trial >= {1'b0, den_q});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         q_q   <= '0;
         rem_q <= '0;
         den_q <= '0;
         cnt_q <= '0;
      end else if (go) begin
         sh_q  <= num;
         den_q <= den;
         rem_q <= '0;
         q_q   <= '0;
         cnt_q <= CNTW'(NUMW);
      end else if (cnt_q != '0) begin
         sh_q  <= {sh_q[NUMW-2:0], 1'b0};
         rem_q <= fits ? DENW'(trial - {1'b0, den_q}) : trial[DENW-1:0];
         q_q   <= {q_q[NUMW-2:0], fits};
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign quo  = q_q;
   assign busy = (cnt_q != '0);
endmodule

// File: rtl/tpg_phase.sv
module tpg_phase #(
   parameter int IW = 16,
   parameter int FW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   input  logic            step,
   input  logic [IW+FW-1:0] period,
   output logic [IW:0]     len
);
   logic [FW-1:0]    frac_q;
   logic [IW+FW:0]   sum;

   assign sum = {1'b0, period} + {{(IW+1){1'b0}}, frac_q};
   assign len = sum[IW+FW:FW];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     frac_q <= '0;
      else if (clear) frac_q <= '0;
      else if (step)  frac_q <= sum[FW-1:0];
   end
endmodule

// File: rtl/tpg_shape.sv
module tpg_shape
   import tpg_pkg::*;
#(
   parameter int DW = 12,
   parameter int CW = 16,
   parameter int RF = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             adv,
   input  logic [DW-1:0]    amp,
   input  logic [CW-1:0]    rise,
   input  logic [CW-1:0]    high,
   input  logic [CW-1:0]    fall,
   input  logic [DW+RF-1:0] inc_r,
   input  logic [DW+RF-1:0] inc_f,
   output logic [DW-1:0]    value
);
   localparam int AW = DW + RF;

   tpg_seg_t        seg_q, tgt;
   logic [CW-1:0]   cnt_q, tgt_len;
   logic [AW-1:0]   acc_q, tgt_acc;
   logic            r_nz, h_nz, f_nz, leave;

   assign r_nz  = (rise != '0);
   assign h_nz  = (high != '0);
   assign f_nz  = (fall != '0);
   assign leave = (seg_q != SG_LOW) && (cnt_q == CW'(1));

   always_comb begin
      tgt = restart ? tpg_first_seg(SG_RISE, r_nz, h_nz, f_nz)
                    : tpg_first_seg(tpg_succ(seg_q), r_nz, h_nz, f_nz);
      case (tgt)
         SG_RISE: tgt_len = rise;
         SG_HIGH: tgt_len = high;
         SG_FALL: tgt_len = fall;
         default: tgt_len = '0;
      endcase
      tgt_acc = (tgt == SG_FALL) ? {amp, {RF{1'b0}}} : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg_q <= SG_LOW;
         cnt_q <= '0;
         acc_q <= '0;
      end else if (restart || (adv && leave)) begin
         seg_q <= tgt;
         cnt_q <= tgt_len;
         acc_q <= tgt_acc;
      end else if (adv && seg_q != SG_LOW) begin
         cnt_q <= cnt_q - 1'b1;
         if (seg_q == SG_RISE)      acc_q <= acc_q + inc_r;
         else if (seg_q == SG_FALL) acc_q <= acc_q - inc_f;
      end
   end

   always_comb begin
      case (seg_q)
         SG_RISE, SG_FALL: value = acc_q[AW-1:RF];
         SG_HIGH:          value = amp;
         default:          value = '0;
      endcase
   end
endmodule

// File: rtl/trap_pulse_gen.sv
module trap_pulse_gen
   import tpg_pkg::*;
#(
   parameter int DW = 12,
   parameter int CW = 16,
   parameter int FW = 8,
   parameter int NW = 16,
   parameter int RF = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             stop,
   input  logic [DW-1:0]    cfg_amp,
   input  logic [CW-1:0]    cfg_rise,
   input  logic [CW-1:0]    cfg_high,
   input  logic [CW-1:0]    cfg_fall,
   input  logic [CW+FW-1:0] cfg_period,
   input  logic [NW-1:0]    cfg_count,
   output logic [DW-1:0]    sample_out,
   output logic             running,
   output logic             period_strobe,
   output logic [NW-1:0]    periods_done,
   output logic             done
);
   localparam int AW = DW + RF;

   generate
      if (DW < 2 || CW < 2 || FW < 1 || RF < 1 || NW < 1) begin : g_bad_param
         $error("trap_pulse_gen: parameter out of range");
      end
   endgenerate

   tpg_state_t        state_q;
   logic [DW-1:0]     amp_q;
   logic [CW-1:0]     rise_q, high_q, fall_q;
   logic [CW+FW-1:0]  per_q;
   logic [NW-1:0]     cnt_q, pdone_q, pd_nxt;
   logic [CW:0]       idx_q, plen_q, len_w;
   logic              accept, setup_ok, in_run, last, finish;
   logic              sh_restart, sh_adv;
   logic [1:0]        busy_w;
   logic [1:0][AW-1:0] inc_w;
   logic [1:0][CW-1:0] den_w;
   logic [DW-1:0]     shape_val;

   assign accept   = start && !stop && (state_q == ST_IDLE || state_q == ST_DONE);
   assign setup_ok = (state_q == ST_SETUP) && !stop && (busy_w == '0);
   assign in_run   = (state_q == ST_RUN);
   assign last     = (idx_q == plen_q - 1'b1);
   assign pd_nxt   = pdone_q + 1'b1;
   assign finish   = in_run && last && (cnt_q != '0) && (pd_nxt == cnt_q);
   assign sh_restart = setup_ok || (in_run && !stop && last && !finish);
   assign sh_adv     = in_run && !stop && !last;
   assign den_w    = {cfg_fall, cfg_rise};

   // one slope divider per ramp
   generate
      for (genvar g = 0; g < 2; g++) begin : g_slope
         tpg_div #(.NUMW(AW), .DENW(CW)) u_div (
            .clk  (clk),
            .rst_n(rst_n),
            .go   (accept),
            .num  ({cfg_amp, {RF{1'b0}}}),
            .den  (den_w[g]),
            .quo  (inc_w[g]),
            .busy (busy_w[g])
         );
      end
   endgenerate

   tpg_phase #(.IW(CW), .FW(FW)) u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (accept),
      .step  (sh_restart),
      .period(per_q),
      .len   (len_w)
   );

   tpg_shape #(.DW(DW), .CW(CW), .RF(RF)) u_shape (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(sh_restart),
      .adv    (sh_adv),
      .amp    (amp_q),
      .rise   (rise_q),
      .high   (high_q),
      .fall   (fall_q),
      .inc_r  (inc_w[0]),
      .inc_f  (inc_w[1]),
      .value  (shape_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         amp_q   <= '0;
         rise_q  <= '0;
         high_q  <= '0;
         fall_q  <= '0;
         per_q   <= '0;
         cnt_q   <= '0;
         pdone_q <= '0;
         idx_q   <= '0;
         plen_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE, ST_DONE: begin
               if (accept) begin
                  amp_q   <= cfg_amp;
                  rise_q  <= cfg_rise;
                  high_q  <= cfg_high;
                  fall_q  <= cfg_fall;
                  per_q   <= cfg_period;
                  cnt_q   <= cfg_count;
                  pdone_q <= '0;
                  state_q <= ST_SETUP;
               end
            end
            ST_SETUP: begin
               if (stop) begin
                  state_q <= ST_IDLE;
               end else if (setup_ok) begin
                  state_q <= ST_RUN;
                  idx_q   <= '0;
                  plen_q  <= len_w;
               end
            end
            default: begin
               if (stop) begin
                  state_q <= ST_IDLE;
               end else if (last) begin
                  pdone_q <= pd_nxt;
                  if (finish) begin
                     state_q <= ST_DONE;
                  end else begin
                     idx_q  <= '0;
                     plen_q <= len_w;
                  end
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
         endcase
      end
   end

   assign running       = in_run;
   assign period_strobe = in_run && (idx_q == '0);
   assign sample_out    = in_run ? shape_val : '0;
   assign periods_done  = pdone_q;
   assign done          = (state_q == ST_DONE);
endmodule

// File: rtl/tpg_chk.sv
module tpg_chk #(
   parameter int DW = 12,
   parameter int NW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic [DW-1:0] sample_out,
   input logic          running,
   input logic          period_strobe,
   input logic          done,
   input logic [NW-1:0] periods_done,
   input logic [DW-1:0] amp_q,
   input logic [NW-1:0] cnt_q
);
   a_r10_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> sample_out == '0);

   a_r2_strobe_only_in_run: assert property (@(posedge clk) disable iff (!rst_n)
      period_strobe |-> running);

   a_r8_done_state: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!running && periods_done == cnt_q));

   a_r9_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (running && $past(running) && !period_strobe) |-> $stable(periods_done));

   a_r9_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (period_strobe && $past(running)) |-> periods_done == NW'($past(periods_done) + 1'b1));

   a_r12_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> sample_out <= amp_q);
endmodule

bind trap_pulse_gen tpg_chk #(.DW(DW), .NW(NW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sample_out   (sample_out),
   .running      (running),
   .period_strobe(period_strobe),
   .done         (done),
   .periods_done (periods_done),
   .amp_q        (amp_q),
   .cnt_q        (cnt_q)
);

// File: tb/trap_pulse_gen_bench.sv
`timescale 1ns/1ps
module trap_pulse_gen_bench;
   localparam int DW = 8, CW = 8, FW = 4, NW = 8, RF = 8;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, stop = 1'b0;
   logic [DW-1:0]    cfg_amp = '0;
   logic [CW-1:0]    cfg_rise = '0, cfg_high = '0, cfg_fall = '0;
   logic [CW+FW-1:0] cfg_period = '0;
   logic [NW-1:0]    cfg_count = '0;
   logic [DW-1:0]    sample_out;
   logic             running, period_strobe, done;
   logic [NW-1:0]    periods_done;

   int checks = 0, errors = 0;

   always #2.5 clk = ~clk;

   trap_pulse_gen #(.DW(DW), .CW(CW), .FW(FW), .NW(NW), .RF(RF)) u_trap_pulse_gen (
      .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
      .cfg_amp(cfg_amp), .cfg_rise(cfg_rise), .cfg_high(cfg_high),
      .cfg_fall(cfg_fall), .cfg_period(cfg_period), .cfg_count(cfg_count),
      .sample_out(sample_out), .running(running), .period_strobe(period_strobe),
      .periods_done(periods_done), .done(done)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int model(input int n, input int a, input int r,
                                input int h, input int f);
      int ir, inf;
      if (n < r) begin
         ir = (a << RF) / r;
         return (n * ir) >> RF;
      end
      if (n < r + h) return a;
      if (n < r + h + f) begin
         inf = (a << RF) / f;
         return ((a << RF) - (n - r - h) * inf) >> RF;
      end
      return 0;
   endfunction

   function automatic string region(input int n, input int r, input int h, input int f);
      if (r == 0 || h == 0 || f == 0) return "R7";
      if (n < r) return "R3";
      if (n < r + h) return "R4";
      if (n < r + h + f) return "R5";
      return "R6";
   endfunction

   task automatic run_case(input int a, input int r, input int h, input int f,
                           input int per, input int cnt, input int nper,
                           input bit disturb);
      int w, len, ev;
      string tag;
      cfg_amp = DW'(a); cfg_rise = CW'(r); cfg_high = CW'(h); cfg_fall = CW'(f);
      cfg_period = (CW+FW)'(per); cfg_count = NW'(cnt);
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      w = 0;
      while (!running && w < 100) begin @(negedge clk); w++; end
      chk(running == 1'b1, "R2 run begins", int'(running), 1);
      for (int k = 0; k < nper; k++) begin
         len = (((k + 1) * per) >> FW) - ((k * per) >> FW);
         for (int n = 0; n < len; n++) begin
            ev  = model(n, a, r, h, f);
            tag = (disturb && k >= 1) ? "R11" : region(n, r, h, f);
            chk(int'(sample_out) == ev, tag, int'(sample_out), ev);
            chk(period_strobe == (n == 0), "R2 strobe", int'(period_strobe), int'(n == 0));
            chk(running == 1'b1, "R2 running", int'(running), 1);
            chk(int'(periods_done) == (k % 256), "R9 count", int'(periods_done), k % 256);
            if (disturb && k == 1 && n == 2) begin
               cfg_amp = ~cfg_amp; cfg_rise = 8'd1; cfg_high = 8'd9;
               cfg_fall = 8'd1; cfg_period = 12'h055; cfg_count = 8'd1;
               start = 1'b1;
            end
            if (disturb && k == 1 && n == 3) start = 1'b0;
            @(negedge clk);
         end
      end
      if (cnt != 0) begin
         chk(done == 1'b1, "R8 done", int'(done), 1);
         chk(running == 1'b0, "R8 not running", int'(running), 0);
         chk(sample_out == '0, "R8 zero", int'(sample_out), 0);
         chk(int'(periods_done) == cnt, "R8 final count", int'(periods_done), cnt);
         repeat (3) @(negedge clk);
         chk(done == 1'b1 && sample_out == '0, "R8 stays", int'(sample_out), 0);
      end else begin
         chk(running == 1'b1 && period_strobe == 1'b1, "R8 continues", int'(running), 1);
         stop = 1'b1;
         @(negedge clk); stop = 1'b0;
         chk(running == 1'b0, "R10 stopped", int'(running), 0);
         chk(done == 1'b0, "R10 no done", int'(done), 0);
         chk(sample_out == '0, "R10 zero", int'(sample_out), 0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int rl[4] = '{0, 1, 3, 7};
      int hl[2] = '{0, 4};
      int fl[3] = '{0, 2, 5};
      int a, s;
      repeat (3) @(negedge clk);
      chk(sample_out == '0, "R1 sample", int'(sample_out), 0);
      chk(running == 1'b0, "R1 running", int'(running), 0);
      chk(period_strobe == 1'b0, "R1 strobe", int'(period_strobe), 0);
      chk(done == 1'b0, "R1 done", int'(done), 0);
      chk(periods_done == '0, "R1 count", int'(periods_done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      foreach (rl[i]) foreach (hl[j]) foreach (fl[m]) begin
         s = rl[i] + hl[j] + fl[m];
         a = ((rl[i] * 37 + hl[j] * 11 + fl[m] * 5) % 255) + 1;
         run_case(a, rl[i], hl[j], fl[m], (30 << FW) + (s * 3) % 16, 2, 2, 1'b0);
      end
      run_case(255, 7, 4, 5, (28 << FW) + 9, 2, 2, 1'b0);
      run_case(200, 7, 3, 7, 20 << FW, 4, 4, 1'b0);
      run_case(200, 3, 5, 4, (23 << FW) + 11, 20, 20, 1'b0);
      run_case(150, 5, 3, 6, (26 << FW) + 5, 3, 3, 1'b1);
      run_case(90, 4, 2, 3, (21 << FW) + 13, 0, 5, 1'b0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule